// File: doc/BRIEF.md
# Polled Character I/O Port

This block joins one character source, such as a keyboard, and one character sink, such as a display, to a shared processor bus. It claims four consecutive byte addresses. The processor finds out when a device needs service only by reading the status register and testing its flags. Received characters are collected in a holding register. Characters to be shown are placed in a second holding register, which then offers them to the sink.

Each bus cycle on the processor side has an address, separate read and write strobes, and write data. Read data is combinational and valid in the cycle of the read strobe. Register updates take effect at the next clock edge.

Both device sides are valid/ready byte streams. The source side never applies back-pressure: `kb_ready` is held high, and a byte that arrives while the previous one is still unread replaces it and is flagged as an overrun. On the sink side, back-pressure is fully honoured. While `disp_ready` is low, `disp_valid` stays high and `disp_data` holds its value until the byte is taken.

The block has two decode modes. In memory-mapped mode the full address is compared with `BASE_ADDR`. In separate I/O-space mode only the low `IO_ADDR_W` address bits are compared, and only while `bus_io_sel` is high.

Top module: `mmio_poll_port`

## Requirements
- R1: In memory-mapped mode the block responds only to addresses BASE_ADDR+0..3 (offset 0 receive data, 1 transmit data, 2 status, 3 control). A read of any other address returns 0, and a write to any other address changes no register.
- R2: `kb_ready` is always 1. A cycle with `kb_valid` high stores `kb_data` as the receive byte and sets status bit 0 at the next edge.
- R3: A read of offset 0 returns the stored receive byte and clears status bit 0. If a new byte arrives in that same cycle, bit 0 stays 1 and the new byte is stored.
- R4: A byte that arrives while status bit 0 is 1, and not during a read of offset 0, replaces the stored byte and sets status bit 2. A read of status clears bit 2, unless a new overrun occurs in that same cycle.
- R5: A write to offset 1 stores the byte, clears status bit 1, and raises `disp_valid` with `disp_data` equal to that byte at the next edge. While `disp_ready` is low, both outputs hold.
- R6: A cycle with `disp_valid` and `disp_ready` both high sets status bit 1 and drops `disp_valid` at the next edge. A write to offset 1 in that same cycle takes priority and leaves bit 1 clear.
- R7: The control register at offset 3 stores all 8 written bits and reads them back. Its value has no effect on any other output.
- R8: Writes to offset 0 and offset 2 change nothing. Status bits 7..3 read as 0. A read of offset 1 returns the last byte written there.
- R9: After reset every register is 0 except status bit 1, which is 1, so status reads 0x02 and `disp_valid` is 0.
- R10: In I/O-space mode the block decodes only address bits IO_ADDR_W-1..0 and only while `bus_io_sel` is 1. In memory-mapped mode `bus_io_sel` is ignored.
- R11: `bus_rdata` is 0 in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Bus address |
| bus_rd_en | input | 1 | Read strobe |
| bus_wr_en | input | 1 | Write strobe |
| bus_io_sel | input | 1 | I/O-space select (used only in I/O-space mode) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| kb_valid | input | 1 | Source byte valid |
| kb_data | input | DATA_W | Source byte |
| kb_ready | output | 1 | Source ready, always 1 |
| disp_valid | output | 1 | Sink byte valid |
| disp_data | output | DATA_W | Sink byte |
| disp_ready | input | 1 | Sink ready |

## Verification
The assertions assume that the processor never raises the read and write strobes in the same cycle. They also assume that the sink's `disp_ready` is a plain level that the block samples only while `disp_valid` is high. The stimulus therefore picks at most one strobe per cycle. It toggles `disp_ready` freely, including long low stretches to exercise back-pressure, and sends source bytes at arbitrary times so that overruns and same-cycle read/arrival collisions occur. A behavioural model in the bench tracks the expected register state and predicts read data and sink outputs on every cycle. A second instance in I/O-space mode receives directed accesses both with and without the select line.

// File: rtl/mmio_poll_pkg.sv
package mmio_poll_pkg;
  localparam int OFS_W = 2;

  typedef enum logic [OFS_W-1:0] {
    REG_RXD  = 2'd0,
    REG_TXD  = 2'd1,
    REG_STAT = 2'd2,
    REG_CTRL = 2'd3
  } reg_ofs_e;

  localparam int STAT_RX_BIT  = 0;
  localparam int STAT_TX_BIT  = 1;
  localparam int STAT_OVR_BIT = 2;

  typedef struct packed {
    logic rxd;
    logic txd;
    logic stat;
    logic ctrl;
  } reg_sel_t;
endpackage

// File: rtl/mmio_poll_decode.sv
module mmio_poll_decode
  import mmio_poll_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IO_SPACE = 0,
  parameter int IO_ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              io_sel,
  input  logic              rd_en,
  input  logic              wr_en,
  output reg_sel_t          rd_sel,
  output reg_sel_t          wr_sel
);
  localparam int CMP_W = (IO_SPACE != 0) ? IO_ADDR_W : ADDR_W;

  logic     match;
  logic     gate_ok;
  reg_sel_t ofs_sel;

  // the select line gates decode only in I/O-space mode
  assign gate_ok = io_sel | (IO_SPACE == 0);

  generate
    if (IO_SPACE != 0) begin : g_io
      assign match = (addr[CMP_W-1:OFS_W] == BASE_ADDR[CMP_W-1:OFS_W]);
    end else begin : g_mem
      assign match = (addr[ADDR_W-1:OFS_W] == BASE_ADDR[ADDR_W-1:OFS_W]);
    end
  endgenerate

  always_comb begin
    ofs_sel = '0;
    unique case (reg_ofs_e'(addr[OFS_W-1:0]))
      REG_RXD:  ofs_sel.rxd  = 1'b1;
      REG_TXD:  ofs_sel.txd  = 1'b1;
      REG_STAT: ofs_sel.stat = 1'b1;
      REG_CTRL: ofs_sel.ctrl = 1'b1;
      default:  ofs_sel      = '0;
    endcase
  end

  assign rd_sel = (match && gate_ok && rd_en) ? ofs_sel : '0;
  assign wr_sel = (match && gate_ok && wr_en) ? ofs_sel : '0;
endmodule

// File: rtl/mmio_poll_rx.sv
module mmio_poll_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_valid,
  input  logic [DATA_W-1:0] dev_data,
  output logic              dev_ready,
  input  logic              take,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] held,
  output logic              full,
  output logic              ovr
);
  logic ovr_set;

  assign dev_ready = 1'b1;
  assign ovr_set   = dev_valid && full && !take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
      full <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      if (dev_valid) begin
        held <= dev_data;
        full <= 1'b1;
      end else if (take) begin
        full <= 1'b0;
      end
      if (ovr_set)      ovr <= 1'b1;
      else if (stat_rd) ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/mmio_poll_tx.sv
module mmio_poll_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] held,
  output logic              empty,
  output logic              dev_valid,
  output logic [DATA_W-1:0] dev_data,
  input  logic              dev_ready
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held  <= '0;
      empty <= 1'b1;
    end else begin
      if (load) begin
        held  <= wdata;
        empty <= 1'b0;
      end else if (!empty && dev_ready) begin
        empty <= 1'b1;
      end
    end
  end

  assign dev_valid = !empty;
  assign dev_data  = held;
endmodule

// File: rtl/mmio_poll_port.sv
module mmio_poll_port
  import mmio_poll_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IO_SPACE = 0,
  parameter int IO_ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd_en,
  input  logic              bus_wr_en,
  input  logic              bus_io_sel,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              kb_valid,
  input  logic [DATA_W-1:0] kb_data,
  output logic              kb_ready,
  output logic              disp_valid,
  output logic [DATA_W-1:0] disp_data,
  input  logic              disp_ready
);
  reg_sel_t          rd_sel;
  reg_sel_t          wr_sel;
  logic              rd_rxd;
  logic              wr_txd;
  logic [DATA_W-1:0] rx_data;
  logic              rx_full;
  logic              rx_ovr;
  logic [DATA_W-1:0] tx_data;
  logic              tx_empty;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] status;

  mmio_poll_decode #(
    .ADDR_W(ADDR_W), .IO_SPACE(IO_SPACE), .IO_ADDR_W(IO_ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .addr(bus_addr), .io_sel(bus_io_sel), .rd_en(bus_rd_en), .wr_en(bus_wr_en),
    .rd_sel(rd_sel), .wr_sel(wr_sel)
  );

  assign rd_rxd = rd_sel.rxd;
  assign wr_txd = wr_sel.txd;

  mmio_poll_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .dev_valid(kb_valid), .dev_data(kb_data),
    .dev_ready(kb_ready), .take(rd_rxd), .stat_rd(rd_sel.stat),
    .held(rx_data), .full(rx_full), .ovr(rx_ovr)
  );

  mmio_poll_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(wr_txd), .wdata(bus_wdata),
    .held(tx_data), .empty(tx_empty), .dev_valid(disp_valid),
    .dev_data(disp_data), .dev_ready(disp_ready)
  );

  // control bits are kept for software only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ctrl_q <= '0;
    else if (wr_sel.ctrl) ctrl_q <= bus_wdata;
  end

  always_comb begin
    status               = '0;
    status[STAT_RX_BIT]  = rx_full;
    status[STAT_TX_BIT]  = tx_empty;
    status[STAT_OVR_BIT] = rx_ovr;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_sel.rxd)  bus_rdata = rx_data;
    if (rd_sel.txd)  bus_rdata = tx_data;
    if (rd_sel.stat) bus_rdata = status;
    if (rd_sel.ctrl) bus_rdata = ctrl_q;
  end
endmodule

// File: rtl/mmio_poll_chk.sv
module mmio_poll_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd_en,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              kb_valid,
  input logic              disp_valid,
  input logic              disp_ready,
  input logic [DATA_W-1:0] disp_data,
  input logic              rx_full,
  input logic              rx_ovr,
  input logic              rd_rxd,
  input logic              wr_txd
);
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_en |-> bus_rdata == '0); // R11
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && !disp_ready && !wr_txd |=> disp_valid && $stable(disp_data)); // R5
  AST_TX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_txd |=> disp_valid); // R5
  AST_TX_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && disp_ready && !wr_txd |=> !disp_valid); // R6
  AST_RX_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    kb_valid |=> rx_full); // R2
  AST_RX_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rxd && !kb_valid |=> !rx_full); // R3
  AST_RX_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    kb_valid && rx_full && !rd_rxd |=> rx_ovr); // R4
endmodule

bind mmio_poll_port mmio_poll_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
  .kb_valid(kb_valid), .disp_valid(disp_valid), .disp_ready(disp_ready),
  .disp_data(disp_data), .rx_full(rx_full), .rx_ovr(rx_ovr),
  .rd_rxd(rd_rxd), .wr_txd(wr_txd)
);

// File: tb/tb_mmio_poll_port.sv
module tb_mmio_poll_port;
  localparam logic [15:0] BASE = 16'h4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] addr = '0;
  logic rd = 0, wr = 0, iosel = 0, kbv = 0, dr = 0;
  logic [7:0] wd = '0, kbd = '0;
  logic [7:0] rdata, ddata;
  logic kbr, dv;

  logic [15:0] io_addr = '0;
  logic io_rd = 0, io_wr = 0, io_sel = 0;
  logic [7:0] io_wd = '0;
  logic [7:0] io_rdata, io_ddata;
  logic io_kbr, io_dv;

  int errors = 0;
  int checks = 0;

  mmio_poll_port #(.BASE_ADDR(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_rd_en(rd), .bus_wr_en(wr),
    .bus_io_sel(iosel), .bus_wdata(wd), .bus_rdata(rdata), .kb_valid(kbv),
    .kb_data(kbd), .kb_ready(kbr), .disp_valid(dv), .disp_data(ddata), .disp_ready(dr)
  );

  mmio_poll_port #(.IO_SPACE(1), .IO_ADDR_W(8), .BASE_ADDR(16'h0020)) dut_io (
    .clk(clk), .rst_n(rst_n), .bus_addr(io_addr), .bus_rd_en(io_rd), .bus_wr_en(io_wr),
    .bus_io_sel(io_sel), .bus_wdata(io_wd), .bus_rdata(io_rdata), .kb_valid(1'b0),
    .kb_data(8'h00), .kb_ready(io_kbr), .disp_valid(io_dv), .disp_data(io_ddata),
    .disp_ready(1'b0)
  );

  // reference state
  logic [7:0] m_rx = 0, m_tx = 0, m_ctl = 0;
  bit m_full = 0, m_ovr = 0, m_empty = 1;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit r, bit w, logic [15:0] a, logic [7:0] d, bit kv, logic [7:0] kd, bit rdy, bit sel);
    bit hit;
    int ofs, exp_rd;
    string tag;
    @(negedge clk);
    rd = r; wr = w; addr = a; wd = d; kbv = kv; kbd = kd; dr = rdy; iosel = sel;
    #1;
    hit = (a[15:2] == BASE[15:2]);
    ofs = a[1:0];
    exp_rd = 0;
    tag = "R11";
    if (r && !hit) tag = "R1";
    if (r && hit) begin
      case (ofs)
        0: begin exp_rd = m_rx; tag = "R3"; end
        1: begin exp_rd = m_tx; tag = "R8"; end
        2: begin exp_rd = {5'b0, m_ovr, m_empty, m_full}; tag = "R4"; end
        default: begin exp_rd = m_ctl; tag = "R7"; end
      endcase
    end
    chk(tag, rdata, exp_rd);
    chk("R6", dv, !m_empty);
    if (!m_empty) chk("R5", ddata, m_tx);
    chk("R2", kbr, 1);
    @(posedge clk);
    if (kv) begin
      if (m_full && !(r && hit && ofs == 0)) m_ovr = 1;
      else if (r && hit && ofs == 2) m_ovr = 0;
      m_rx = kd; m_full = 1;
    end else begin
      if (r && hit && ofs == 0) m_full = 0;
      if (r && hit && ofs == 2) m_ovr = 0;
    end
    if (w && hit && ofs == 1) begin m_tx = d; m_empty = 0; end
    else if (!m_empty && rdy) m_empty = 1;
    if (w && hit && ofs == 3) m_ctl = d;
  endtask

  task automatic idle(int n, bit rdy);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, rdy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", dv, 0);
    rd = 1; addr = BASE + 2; #1;
    chk("R9", rdata, 8'h02);
    rd = 0;
    @(negedge clk); rst_n = 1;
    // receive path
    step(0, 0, 0, 0, 1, 8'h41, 0, 0);
    step(1, 0, BASE + 2, 0, 0, 0, 0, 0);
    step(1, 0, BASE + 0, 0, 0, 0, 0, 0);
    step(1, 0, BASE + 2, 0, 0, 0, 0, 0);
    // overrun and its clear
    step(0, 0, 0, 0, 1, 8'h11, 0, 0);
    step(0, 0, 0, 0, 1, 8'h22, 0, 0);
    step(1, 0, BASE + 2, 0, 0, 0, 0, 0);
    step(1, 0, BASE + 2, 0, 0, 0, 0, 0);
    // read collides with a new arrival
    step(1, 0, BASE + 0, 0, 1, 8'h33, 0, 0);
    step(1, 0, BASE + 2, 0, 0, 0, 0, 0);
    step(1, 0, BASE + 0, 0, 0, 0, 0, 0);
    // status read with simultaneous overrun keeps bit 2
    step(0, 0, 0, 0, 1, 8'h44, 0, 0);
    step(1, 0, BASE + 2, 0, 1, 8'h45, 0, 0);
    step(1, 0, BASE + 2, 0, 0, 0, 0, 0);
    // transmit with back-pressure
    step(0, 1, BASE + 1, 8'h55, 0, 0, 0, 0);
    idle(4, 0);
    step(1, 0, BASE + 2, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    step(1, 0, BASE + 2, 0, 0, 0, 0, 0);
    // write in the handshake cycle wins
    step(0, 1, BASE + 1, 8'h66, 0, 0, 0, 0);
    step(0, 1, BASE + 1, 8'h77, 0, 0, 1, 0);
    step(1, 0, BASE + 1, 0, 0, 0, 0, 0);
    idle(2, 1);
    // control, ignored writes and foreign addresses
    step(0, 1, BASE + 3, 8'hA5, 0, 0, 0, 1);
    step(1, 0, BASE + 3, 0, 0, 0, 0, 0);
    step(0, 1, BASE + 2, 8'hFF, 0, 0, 0, 0);
    step(0, 1, BASE + 0, 8'hFF, 0, 0, 0, 0);
    step(1, 0, BASE + 2, 0, 0, 0, 0, 0);
    step(0, 1, BASE + 4, 8'h99, 0, 0, 0, 0);
    step(0, 1, BASE - 1, 8'h98, 0, 0, 0, 0);
    step(1, 0, BASE + 4, 0, 0, 0, 0, 0);
    step(1, 0, BASE + 3, 0, 0, 0, 0, 0);
    step(1, 0, BASE + 1, 0, 0, 0, 0, 0);
    // randomised traffic
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [15:0] a;
      op = $urandom_range(0, 2);
      a = ($urandom_range(0, 7) == 0) ? 16'($urandom) : BASE + 16'($urandom_range(0, 3));
      step(op == 1, op == 2, a, 8'($urandom), $urandom_range(0, 3) == 0,
           8'($urandom), $urandom_range(0, 2) != 0, 1'($urandom));
    end
    // I/O-space instance
    @(negedge clk); io_wr = 1; io_sel = 1; io_addr = 16'hFF23; io_wd = 8'h5A;
    @(negedge clk); io_wr = 0; io_rd = 1; io_addr = 16'h0023; #1;
    chk("R10", io_rdata, 8'h5A);
    io_sel = 0; #1;
    chk("R10", io_rdata, 0);
    io_rd = 0; io_wr = 1; io_wd = 8'h11;
    @(negedge clk); io_wr = 0; io_rd = 1; io_sel = 1; #1;
    chk("R10", io_rdata, 8'h5A);
    io_addr = 16'h0027; #1;
    chk("R10", io_rdata, 0);
    io_rd = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule